// File: doc/BRIEF.md
# Tiled Matrix-Multiply Sequencer

This controller computes C = A × B for operands of any size from 1 up to `MAX_DIM` on each side. It uses a square systolic array of fixed edge `TILE`, which sits outside the block. The logical M×K and K×N operands stay in on-chip scratchpads that the sequencer reads directly. It cuts the problem into TILE×TILE pieces. For each output tile it streams one operand tile pair per K-tile into the array. It collects the partial tile sum that the array returns and keeps the running total in an internal accumulator. When the last K-tile has been added, it writes the finished tile out through a single write port.

When M, K or N is not a multiple of `TILE`, the edge tiles are filled with zeros as they are fed. The sequencer compares each row and column index against the configured dimensions and masks the lanes that fall outside. No padded copy is stored and no out-of-range scratchpad location is read. Padded lanes still use their slots in the array, so every tile pair takes the same number of cycles. Padded output positions are dropped at write-back.

A start pulse while idle captures the three dimensions and begins the run. A one-cycle done pulse ends it.

Top module: `tmm_seq`

## Requirements
- R1: After reset the block is idle: busy and done are 0, no read enable, array valid or write enable is active.
- R2: A start seen while idle captures cfg_m, cfg_k and cfg_n, and busy is 1 on the next cycle. A start, or a change of the cfg inputs, while busy has no effect on the run.
- R3: Output tiles are processed with tile rows outermost and tile columns next. K-tiles are innermost. Within a tile, the write slots go row-major. A write address is {row, col}: the row in the upper IDX_W bits and the column in the lower IDX_W bits.
- R4: Each tile pair takes TILE read slots. In slot s, A lane r reads (i0+r, k0+s) and B lane c reads (k0+s, j0+c), with the same {row, col} address encoding. A lane's read enable is 1 only when both indices are inside the configured dimensions. Read data is taken one cycle after the slot.
- R5: arr_valid is 1 in the cycle after each read slot. A lane whose read was disabled is presented as zero. Every tile pair gives exactly TILE valid cycles, padded ones included, and arr_last marks the final one.
- R6: The partial tile result is accepted in the cycle arr_res_valid is 1. The result of the first K-tile replaces the accumulator contents, and each later K-tile's result is added to them.
- R7: After the last K-tile of an output tile there are TILE×TILE write slots. c_wr_en is 1 only for elements with row < M and col < N. c_wr_data is the exact signed sum over k of A[row][k]·B[k][col].
- R8: done is a one-cycle pulse in the cycle after the final write slot of the last output tile, and busy is 0 in that cycle.
- R9: Every combination of M, K and N from 1 to MAX_DIM is handled, including sizes that are not multiples of TILE and the maximum size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| cfg_m | input | DIM_W | Rows of A and C |
| cfg_k | input | DIM_W | Shared inner dimension |
| cfg_n | input | DIM_W | Columns of B and C |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| a_rd_en | output | TILE | Per-lane read enable into the A scratchpad |
| a_rd_addr | output | TILE*ADDR_W | Per-lane A address {row, col} |
| a_rd_data | input | TILE*DW | A read data, one cycle after the enable |
| b_rd_en | output | TILE | Per-lane read enable into the B scratchpad |
| b_rd_addr | output | TILE*ADDR_W | Per-lane B address {row, col} |
| b_rd_data | input | TILE*DW | B read data, one cycle after the enable |
| arr_valid | output | 1 | Operand vectors to the array are valid |
| arr_last | output | 1 | Final step of the current tile pair |
| arr_a | output | TILE*DW | A column vector for the array (signed lanes) |
| arr_b | output | TILE*DW | B row vector for the array (signed lanes) |
| arr_res_valid | input | 1 | Partial tile result from the array is valid |
| arr_res | input | TILE*TILE*ACC_W | Partial tile result, row-major, signed |
| c_wr_en | output | 1 | Output element write enable |
| c_wr_addr | output | ADDR_W | Output element address {row, col} |
| c_wr_data | output | ACC_W | Output element value (signed) |

## Verification
busy rises one cycle after an accepted start. Array operands appear one cycle after their read slot, and four cycles separate the first read slot from arr_last. The partial result is taken in the same cycle it arrives. done follows the last write-back slot, which comes TILE×TILE minus the slot index of the last in-range element after that element's write. The bench drives and samples every signal on the falling clock edge. Its array and scratchpad models answer on the falling edge after a request, so each response lines up with the rising edge at which the design expects it. The done cycle is predicted from the configured M and N and compared exactly.

// File: rtl/tmm_pkg.sv
// Shared types for the tiled matrix-multiply sequencer.
package tmm_pkg;

    // Sequencer phases: idle, issue operand reads, wait for the array, write back.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FEED  = 2'd1,
        S_WAIT  = 2'd2,
        S_WRITE = 2'd3
    } tmm_state_e;

endpackage

// File: rtl/tmm_tile_loop.sv
// Tile loop counters: keeps the element base of the current output tile
// (row, column) and of the current K-tile, and flags the final iterations.
// Assumes step_k and step_out never coincide and that every dimension is >= 1.
module tmm_tile_loop #(
    parameter int TILE  = 4,
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step_k,
    input  logic             step_out,
    input  logic [POS_W-1:0] dim_m,
    input  logic [POS_W-1:0] dim_k,
    input  logic [POS_W-1:0] dim_n,
    output logic [POS_W-1:0] row_base,
    output logic [POS_W-1:0] col_base,
    output logic [POS_W-1:0] k_base,
    output logic             k_first,
    output logic             k_last,
    output logic             out_last
);
    localparam logic [POS_W-1:0] TSTEP = POS_W'(TILE);

    logic [POS_W-1:0] row_nx, col_nx, k_nx;
    logic             col_last, row_last;

    // Next bases and end-of-dimension flags.
    always_comb begin
        row_nx   = row_base + TSTEP;
        col_nx   = col_base + TSTEP;
        k_nx     = k_base + TSTEP;
        k_first  = (k_base == '0);
        k_last   = (k_nx >= dim_k);
        col_last = (col_nx >= dim_n);
        row_last = (row_nx >= dim_m);
        out_last = row_last && col_last;
    end

    // Advance K innermost, then output column, then output row.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            row_base <= '0;
            col_base <= '0;
            k_base   <= '0;
        end else if (step_k) begin
            k_base <= k_nx;
        end else if (step_out) begin
            k_base <= '0;
            if (col_last) begin
                col_base <= '0;
                row_base <= row_nx;
            end else begin
                col_base <= col_nx;
            end
        end
    end

    // R3: the two advance requests come from different FSM phases.
    p_step_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_k && step_out));

endmodule

// File: rtl/tmm_operand_fetch.sv
// Operand fetch: issues one column slice of the A tile and one row slice
// of the B tile per slot, enables only in-range lanes, and presents the
// returned data to the array with disabled lanes forced to zero.
// Assumes scratchpad read latency of exactly one cycle.
module tmm_operand_fetch #(
    parameter int TILE  = 4,
    parameter int DW    = 8,
    parameter int POS_W = 7,
    parameter int IDX_W = 6,
    localparam int SW     = $clog2(TILE),
    localparam int ADDR_W = 2 * IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic [SW-1:0]          step,
    input  logic [POS_W-1:0]       row_base,
    input  logic [POS_W-1:0]       col_base,
    input  logic [POS_W-1:0]       k_base,
    input  logic [POS_W-1:0]       dim_m,
    input  logic [POS_W-1:0]       dim_k,
    input  logic [POS_W-1:0]       dim_n,
    output logic [TILE-1:0]        a_rd_en,
    output logic [TILE*ADDR_W-1:0] a_rd_addr,
    input  logic [TILE*DW-1:0]     a_rd_data,
    output logic [TILE-1:0]        b_rd_en,
    output logic [TILE*ADDR_W-1:0] b_rd_addr,
    input  logic [TILE*DW-1:0]     b_rd_data,
    output logic                   arr_valid,
    output logic                   arr_last,
    output logic [TILE*DW-1:0]     arr_a,
    output logic [TILE*DW-1:0]     arr_b
);
    logic [POS_W-1:0] k_pos;
    logic             k_ok;
    logic [TILE-1:0]  a_mask_q, b_mask_q;

    assign k_pos = k_base + POS_W'(step);
    assign k_ok  = issue && (k_pos < dim_k);

    for (genvar g = 0; g < TILE; g++) begin : g_lane
        logic [POS_W-1:0] a_row, b_col;
        // Lane addresses and range masks for this slot.
        assign a_row = row_base + POS_W'(g);
        assign b_col = col_base + POS_W'(g);
        assign a_rd_en[g] = k_ok && (a_row < dim_m);
        assign b_rd_en[g] = k_ok && (b_col < dim_n);
        assign a_rd_addr[g*ADDR_W +: ADDR_W] = {a_row[IDX_W-1:0], k_pos[IDX_W-1:0]};
        assign b_rd_addr[g*ADDR_W +: ADDR_W] = {k_pos[IDX_W-1:0], b_col[IDX_W-1:0]};
        // Zero-substitute lanes whose read was not enabled.
        assign arr_a[g*DW +: DW] = a_mask_q[g] ? a_rd_data[g*DW +: DW] : '0;
        assign arr_b[g*DW +: DW] = b_mask_q[g] ? b_rd_data[g*DW +: DW] : '0;
    end

    // Delay masks and slot markers to line up with the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_mask_q  <= '0;
            b_mask_q  <= '0;
            arr_valid <= 1'b0;
            arr_last  <= 1'b0;
        end else begin
            a_mask_q  <= a_rd_en;
            b_mask_q  <= b_rd_en;
            arr_valid <= issue;
            arr_last  <= issue && (step == SW'(TILE - 1));
        end
    end

    // R5: the end marker only ever accompanies a valid step.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_last |-> arr_valid);

endmodule

// File: rtl/tmm_acc_buf.sv
// Output-tile accumulator: TILE x TILE signed registers that are loaded
// with the first partial result, summed with later ones, and read one
// element at a time for write-back.
module tmm_acc_buf #(
    parameter int TILE  = 4,
    parameter int ACC_W = 24,
    localparam int EL = TILE * TILE,
    localparam int IW = $clog2(EL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                accum,
    input  logic [EL*ACC_W-1:0] res,
    input  logic [IW-1:0]       rd_idx,
    output logic [ACC_W-1:0]    rd_data
);
    logic [ACC_W-1:0] acc [EL];

    // Replace or add the whole partial tile in one cycle.
    always_ff @(posedge clk) begin
        for (int e = 0; e < EL; e++) begin
            if (!rst_n)     acc[e] <= '0;
            else if (load)  acc[e] <= res[e*ACC_W +: ACC_W];
            else if (accum) acc[e] <= acc[e] + res[e*ACC_W +: ACC_W];
        end
    end

    assign rd_data = acc[rd_idx];

    // R6: a partial result is either a first load or an addition, never both.
    p_load_accum_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && accum));

endmodule

// File: rtl/tmm_seq.sv
// Tiled matrix-multiply sequencer top: FSM that walks output tiles and
// K-tiles, drives operand fetch, accepts partial results from an external
// systolic array and writes finished in-range elements back.
// Assumes TILE is a power of two >= 2 and 1 <= M, K, N <= MAX_DIM at start.
module tmm_seq
    import tmm_pkg::*;
#(
    parameter int TILE    = 4,
    parameter int DW      = 8,
    parameter int ACC_W   = 24,
    parameter int MAX_DIM = 64,
    localparam int DIM_W  = $clog2(MAX_DIM + 1),
    localparam int IDX_W  = $clog2(MAX_DIM),
    localparam int ADDR_W = 2 * IDX_W,
    localparam int POS_W  = $clog2(MAX_DIM + TILE),
    localparam int SW     = $clog2(TILE),
    localparam int WW     = $clog2(TILE * TILE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [DIM_W-1:0]            cfg_m,
    input  logic [DIM_W-1:0]            cfg_k,
    input  logic [DIM_W-1:0]            cfg_n,
    output logic                        busy,
    output logic                        done,
    output logic [TILE-1:0]             a_rd_en,
    output logic [TILE*ADDR_W-1:0]      a_rd_addr,
    input  logic [TILE*DW-1:0]          a_rd_data,
    output logic [TILE-1:0]             b_rd_en,
    output logic [TILE*ADDR_W-1:0]      b_rd_addr,
    input  logic [TILE*DW-1:0]          b_rd_data,
    output logic                        arr_valid,
    output logic                        arr_last,
    output logic [TILE*DW-1:0]          arr_a,
    output logic [TILE*DW-1:0]          arr_b,
    input  logic                        arr_res_valid,
    input  logic [TILE*TILE*ACC_W-1:0]  arr_res,
    output logic                        c_wr_en,
    output logic [ADDR_W-1:0]           c_wr_addr,
    output logic [ACC_W-1:0]            c_wr_data
);
    tmm_state_e       state;
    logic [SW-1:0]    step_q;
    logic [WW-1:0]    w_q;
    logic [POS_W-1:0] m_q, k_q, n_q;
    logic [POS_W-1:0] row_base, col_base, k_base;
    logic [POS_W-1:0] wr_row, wr_col;
    logic             k_first, k_last, out_last, w_last, res_take;
    logic             loop_init, step_k, step_out;

    // Phase decodes that steer the loop counters and accumulator.
    always_comb begin
        w_last    = (w_q == WW'(TILE * TILE - 1));
        res_take  = (state == S_WAIT) && arr_res_valid;
        loop_init = (state == S_IDLE) && start;
        step_k    = res_take && !k_last;
        step_out  = (state == S_WRITE) && w_last && !out_last;
    end

    // Main sequencer: accept start, issue slots, wait, write back, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            step_q <= '0;
            w_q    <= '0;
            m_q    <= '0;
            k_q    <= '0;
            n_q    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    m_q    <= POS_W'(cfg_m);
                    k_q    <= POS_W'(cfg_k);
                    n_q    <= POS_W'(cfg_n);
                    step_q <= '0;
                    state  <= S_FEED;
                end
                S_FEED: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == SW'(TILE - 1)) state <= S_WAIT;
                end
                S_WAIT: if (arr_res_valid) begin
                    step_q <= '0;
                    w_q    <= '0;
                    state  <= k_last ? S_WRITE : S_FEED;
                end
                S_WRITE: begin
                    w_q <= w_q + 1'b1;
                    if (w_last) begin
                        step_q <= '0;
                        if (out_last) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= S_FEED;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    tmm_tile_loop #(.TILE(TILE), .POS_W(POS_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .init(loop_init),
        .step_k(step_k), .step_out(step_out),
        .dim_m(m_q), .dim_k(k_q), .dim_n(n_q),
        .row_base(row_base), .col_base(col_base), .k_base(k_base),
        .k_first(k_first), .k_last(k_last), .out_last(out_last)
    );

    tmm_operand_fetch #(.TILE(TILE), .DW(DW), .POS_W(POS_W), .IDX_W(IDX_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .issue(state == S_FEED), .step(step_q),
        .row_base(row_base), .col_base(col_base), .k_base(k_base),
        .dim_m(m_q), .dim_k(k_q), .dim_n(n_q),
        .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
        .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
        .arr_valid(arr_valid), .arr_last(arr_last), .arr_a(arr_a), .arr_b(arr_b)
    );

    tmm_acc_buf #(.TILE(TILE), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .load(res_take && k_first), .accum(res_take && !k_first),
        .res(arr_res), .rd_idx(w_q), .rd_data(c_wr_data)
    );

    // Write-back slot position and in-range gating.
    always_comb begin
        wr_row    = row_base + POS_W'(w_q[WW-1:SW]);
        wr_col    = col_base + POS_W'(w_q[SW-1:0]);
        c_wr_en   = (state == S_WRITE) && (wr_row < m_q) && (wr_col < n_q);
        c_wr_addr = {wr_row[IDX_W-1:0], wr_col[IDX_W-1:0]};
    end

    // R8: done lasts one cycle and coincides with the return to idle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: captured dimensions hold for the whole run.
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(m_q) && $stable(k_q) && $stable(n_q)));
    // R4: scratchpad reads happen only in issue slots.
    p_read_in_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|a_rd_en || |b_rd_en) |-> (state == S_FEED));
    // R7: element writes happen only in write-back slots.
    p_write_in_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_en |-> (state == S_WRITE));
    // R6: array results are only offered while a result is awaited.
    p_res_when_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_res_valid |-> (state == S_WAIT));
    // R3: the K-tile base never leaves the configured inner dimension.
    p_kbase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (k_base < k_q));

endmodule

// File: tb/tmm_seq_test.sv
// Self-checking bench: models the scratchpads and the array on the falling
// edge, sweeps small dimensions, and checks every written element.
module tmm_seq_test;
    localparam int T = 4, DW = 8, AW = 24, MAXD = 64, IDXW = 6, AD = 12, DIMW = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n, start;
    logic [DIMW-1:0]      cfg_m, cfg_k, cfg_n;
    logic                 busy, done;
    logic [T-1:0]         a_rd_en, b_rd_en;
    logic [T*AD-1:0]      a_rd_addr, b_rd_addr;
    logic [T*DW-1:0]      a_rd_data, b_rd_data;
    logic                 arr_valid, arr_last;
    logic [T*DW-1:0]      arr_a, arr_b;
    logic                 arr_res_valid;
    logic [T*T*AW-1:0]    arr_res;
    logic                 c_wr_en;
    logic [AD-1:0]        c_wr_addr;
    logic [AW-1:0]        c_wr_data;

    tmm_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n),
        .busy(busy), .done(done),
        .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
        .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
        .arr_valid(arr_valid), .arr_last(arr_last), .arr_a(arr_a), .arr_b(arr_b),
        .arr_res_valid(arr_res_valid), .arr_res(arr_res),
        .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data)
    );

    int memA [MAXD*MAXD];
    int memB [MAXD*MAXD];
    int exp_addr [MAXD*MAXD];
    int exp_val [MAXD*MAXD];
    int psum [T*T];
    int exp_cnt, wr_idx, done_cnt, last_wr_cyc, last_slot, steps;
    int run_m, run_k, run_n;
    int cyc = 0;
    int tests = 0, fails = 0;
    bit run_done;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv,
                       input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (M=%0d K=%0d N=%0d)",
                     req, what, act, expv, run_m, run_k, run_n);
        end
    endtask

    // Falling-edge models: array, write monitor, done monitor, scratchpads.
    always @(negedge clk) begin
        arr_res_valid = 1'b0;
        if (rst_n) begin
            if (arr_valid) begin
                for (int r = 0; r < T; r++) begin
                    for (int c = 0; c < T; c++) begin
                        int av, bv;
                        av = $signed(arr_a[r*DW +: DW]);
                        bv = $signed(arr_b[c*DW +: DW]);
                        psum[r*T+c] += av * bv;
                    end
                end
                steps++;
                if (arr_last) begin
                    chk(steps == T, "R5", steps, T, "array steps per tile pair");
                    for (int e = 0; e < T*T; e++) begin
                        arr_res[e*AW +: AW] = AW'(psum[e]);
                        psum[e] = 0;
                    end
                    arr_res_valid = 1'b1;
                    steps = 0;
                end
            end
            if (c_wr_en) begin
                if (wr_idx < exp_cnt) begin
                    chk(int'(c_wr_addr) == exp_addr[wr_idx], "R3", int'(c_wr_addr),
                        exp_addr[wr_idx], "write address order");
                    chk($signed(c_wr_data) == exp_val[wr_idx], "R6", int'($signed(c_wr_data)),
                        exp_val[wr_idx], "accumulated element value");
                end else begin
                    chk(1'b0, "R7", wr_idx, exp_cnt, "write to padded or extra position");
                end
                wr_idx++;
                last_wr_cyc = cyc;
            end
            if (done) begin
                done_cnt++;
                chk(!busy, "R8", int'(busy), 0, "busy with done");
                chk(cyc == last_wr_cyc + (T*T - last_slot), "R8", cyc,
                    last_wr_cyc + (T*T - last_slot), "done cycle");
                run_done = 1'b1;
            end
            for (int g = 0; g < T; g++) begin
                int ar, ac, br, bc;
                ar = int'(a_rd_addr[g*AD+IDXW +: IDXW]);
                ac = int'(a_rd_addr[g*AD +: IDXW]);
                br = int'(b_rd_addr[g*AD+IDXW +: IDXW]);
                bc = int'(b_rd_addr[g*AD +: IDXW]);
                a_rd_data[g*DW +: DW] = 8'hA5;
                b_rd_data[g*DW +: DW] = 8'h5B;
                if (a_rd_en[g]) begin
                    chk(ar < run_m && ac < run_k, "R4", ar*100+ac, run_m*100+run_k, "A read in range");
                    a_rd_data[g*DW +: DW] = DW'(memA[ar*MAXD+ac]);
                end
                if (b_rd_en[g]) begin
                    chk(br < run_k && bc < run_n, "R4", br*100+bc, run_k*100+run_n, "B read in range");
                    b_rd_data[g*DW +: DW] = DW'(memB[br*MAXD+bc]);
                end
            end
        end
    end

    // Fill operands and compute the expected write sequence.
    task automatic prep(input int m, input int k, input int n, input int seed);
        int li, lj;
        run_m = m; run_k = k; run_n = n;
        for (int r = 0; r < m; r++)
            for (int c = 0; c < k; c++) memA[r*MAXD+c] = ((r*5 + c*3 + seed) % 17) - 8;
        for (int r = 0; r < k; r++)
            for (int c = 0; c < n; c++) memB[r*MAXD+c] = ((r*2 + c*7 + seed*3) % 13) - 6;
        exp_cnt = 0;
        for (int i0 = 0; i0 < m; i0 += T)
            for (int j0 = 0; j0 < n; j0 += T)
                for (int r = 0; r < T; r++)
                    for (int c = 0; c < T; c++)
                        if (i0 + r < m && j0 + c < n) begin
                            int s;
                            s = 0;
                            for (int q = 0; q < k; q++)
                                s += memA[(i0+r)*MAXD+q] * memB[q*MAXD+j0+c];
                            exp_addr[exp_cnt] = (i0 + r) * MAXD + (j0 + c);
                            exp_val[exp_cnt]  = s;
                            exp_cnt++;
                        end
        li = ((m - 1) / T) * T;
        lj = ((n - 1) / T) * T;
        last_slot = (m - 1 - li) * T + (n - 1 - lj);
        wr_idx = 0; done_cnt = 0; run_done = 1'b0; steps = 0;
        for (int e = 0; e < T*T; e++) psum[e] = 0;
    endtask

    task automatic run(input int m, input int k, input int n, input int seed, input bit poke);
        prep(m, k, n, seed);
        @(negedge clk);
        cfg_m = DIMW'(m); cfg_k = DIMW'(k); cfg_n = DIMW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2", int'(busy), 1, "busy after start");
        if (poke) begin
            repeat (20) @(negedge clk);
            cfg_m = 7'd3; cfg_k = 7'd2; cfg_n = 7'd5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R2", int'(busy), 1, "start while busy ignored");
        end
        while (!run_done) @(negedge clk);
        chk(wr_idx == exp_cnt, "R7", wr_idx, exp_cnt, "in-range element count");
        chk(done_cnt == 1, "R8", done_cnt, 1, "done pulses per run");
        @(negedge clk);
        chk(!done && !busy, "R8", int'(done), 0, "done is one cycle");
    endtask

    initial begin
        int dv [6] = '{1, 3, 4, 5, 8, 9};
        int seed;
        rst_n = 1'b0; start = 1'b0; cfg_m = 7'd1; cfg_k = 7'd1; cfg_n = 7'd1;
        arr_res = '0; a_rd_data = '0; b_rd_data = '0; arr_res_valid = 1'b0;
        run_m = 1; run_k = 1; run_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle outputs after reset
        chk(!busy && !done, "R1", int'(busy) + int'(done), 0, "busy/done after reset");
        chk(a_rd_en == '0 && b_rd_en == '0, "R1", int'(a_rd_en) + int'(b_rd_en), 0, "reads after reset");
        chk(!arr_valid && !c_wr_en, "R1", int'(arr_valid) + int'(c_wr_en), 0, "feed/write after reset");
        // R9 sweep over small sizes, aligned and ragged
        seed = 0;
        foreach (dv[i]) foreach (dv[j]) foreach (dv[l]) begin
            run(dv[i], dv[j], dv[l], seed, 1'b0);
            seed++;
        end
        // R9 maximum size, with a start and new dimensions offered mid-run (R2)
        run(64, 6, 64, 11, 1'b1);
        run(2, 64, 7, 5, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule